// File: doc/BRIEF.md
# Predicated Instruction Issue Gate

This block sits between instruction fetch and the execute units of a 16-bit core whose instructions are 32 bits long. It keeps the two condition flags, A and B, in a small register. For every valid instruction word it reads the predicate nibble at the top of the word. That nibble holds an enable bit and a required value for each flag. The block raises an execute enable only when every enabled flag holds its required value. An instruction whose predicate fails is retired as a no-op. Downstream logic must then drop its register write, memory request and flag write.

The execute units send flag updates back through a set of write ports. Each port carries a valid bit, a flag select (0 picks A, 1 picks B) and the new value. All updates land at the next clock edge, so the predicate of the following instruction already sees them. When several ports hit the same flag in one cycle, the port with the highest index wins. Because each instruction carries its own predicate, a negated condition costs nothing extra.

Top module: `pred_gate`

## Requirements
- R1: While reset is asserted and after it is released, before any write, both flags read 0 on `flags_o` (bit 0 is A, bit 1 is B).
- R2: A valid instruction with bits 31 and 30 both clear raises `exec_en_o` whatever the flags hold.
- R3: When bit 31 (A enable) is set, a valid instruction executes only if flag A equals bit 29.
- R4: When bit 30 (B enable) is set, a valid instruction executes only if flag B equals bit 28.
- R5: When both enables are set, both comparisons must hold for the instruction to execute.
- R6: `exec_en_o` is low whenever `instr_valid_i` is low. `suppress_o` is high exactly when a valid instruction fails its predicate.
- R7: A write with select 0 changes only flag A, and one with select 1 changes only flag B. The new value appears on `flags_o` and in the predicate result from the cycle after the write.
- R8: If several write ports target the same flag in one cycle, the highest-numbered port's value is stored.
- R9: With no write valid, both flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word, predicate in bits 31:28 |
| exec_en_o | output | 1 | Instruction may execute |
| suppress_o | output | 1 | Valid instruction retired as no-op |
| flag_wr_valid_i | input | N_WR | Per-port flag write request |
| flag_wr_sel_i | input | N_WR | Per-port flag select, 0 = A, 1 = B |
| flag_wr_val_i | input | N_WR | Per-port value to store |
| flags_o | output | 2 | Current flags, bit 0 A, bit 1 B |

## Verification
Directed words cover each of the four enable combinations, against flag states that both match and do not match the required bits. This separates a missing comparison from an inverted one, and separates an AND of the two checks from an OR. Back-to-back cycles set a flag and then test it, which exposes a one-cycle lag between the write and the predicate. A long random stream mixes idle cycles, single writes, writes to both flags, and colliding writes to the same flag. That stream tells a wrong select, a wrong priority and an unwanted hold or update apart, because the flag on the other side stays unaffected.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned NUM_FLAGS = 2;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  typedef struct packed {
    flag_vec_t en;
    flag_vec_t req;
  } pred_t;

  // Flag i enable at bit INSTR_W-1-i, required value NUM_FLAGS bits lower.
  function automatic pred_t get_pred(input logic [INSTR_W-1:0] instr);
    pred_t p;
    for (int i = 0; i < NUM_FLAGS; i++) begin
      p.en[i]  = instr[INSTR_W-1-i];
      p.req[i] = instr[INSTR_W-1-NUM_FLAGS-i];
    end
    return p;
  endfunction
endpackage

// File: rtl/pred_eval.sv
module pred_eval
  import pred_pkg::*;
(
  input  logic      valid_i,
  input  pred_t     pred_i,
  input  flag_vec_t flags_i,
  output logic      exec_o
);
  flag_vec_t ok;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_term
    assign ok[i] = !pred_i.en[i] || (flags_i[i] == pred_i.req[i]);
  end

  assign exec_o = valid_i && (&ok);
endmodule

// File: rtl/pred_flag_reg.sv
module pred_flag_reg
  import pred_pkg::*;
#(
  parameter int unsigned N_WR = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_WR-1:0] wr_valid_i,
  input  logic [N_WR-1:0] wr_sel_i,
  input  logic [N_WR-1:0] wr_val_i,
  output flag_vec_t       flags_o
);
  flag_vec_t flags_q, flags_d;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    // Later ports override earlier ones.
    always_comb begin
      flags_d[f] = flags_q[f];
      for (int k = 0; k < N_WR; k++) begin
        if (wr_valid_i[k] && (int'(wr_sel_i[k]) == f)) flags_d[f] = wr_val_i[k];
      end
    end

    a_r7_untouched_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (((wr_valid_i & (f == 0 ? ~wr_sel_i : wr_sel_i)) == '0)) |=> $stable(flags_q[f]))
      else $error("a_r7_untouched_flag_holds");
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i == '0) |=> $stable(flags_q))
    else $error("a_r9_idle_hold");

  a_r8_top_port_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i[N_WR-1] |=> (flags_q[$past(wr_sel_i[N_WR-1])] == $past(wr_val_i[N_WR-1])))
    else $error("a_r8_top_port_wins");
endmodule

// File: rtl/pred_gate.sv
module pred_gate
  import pred_pkg::*;
#(
  parameter int unsigned N_WR = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               instr_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               exec_en_o,
  output logic               suppress_o,
  input  logic [N_WR-1:0]    flag_wr_valid_i,
  input  logic [N_WR-1:0]    flag_wr_sel_i,
  input  logic [N_WR-1:0]    flag_wr_val_i,
  output logic [NUM_FLAGS-1:0] flags_o
);
  flag_vec_t flags;
  pred_t     pred;
  logic      exec;

  assign pred = get_pred(instr_i);

  pred_flag_reg #(.N_WR(N_WR)) i_flag_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (flag_wr_valid_i),
    .wr_sel_i   (flag_wr_sel_i),
    .wr_val_i   (flag_wr_val_i),
    .flags_o    (flags)
  );

  pred_eval i_eval (
    .valid_i (instr_valid_i),
    .pred_i  (pred),
    .flags_i (flags),
    .exec_o  (exec)
  );

  assign exec_en_o  = exec;
  assign suppress_o = instr_valid_i && !exec;
  assign flags_o    = flags;

  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |-> (flags_o == '0))
    else $error("a_r1_reset_clear");

  a_r6_idle_no_exec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_valid_i |-> !exec_en_o && !suppress_o)
    else $error("a_r6_idle_no_exec");

  a_r2_open_pred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[31:30] == 2'b00) |-> exec_en_o)
    else $error("a_r2_open_pred");

  a_r3_a_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[31] && (flags_o[0] != instr_i[29])) |-> suppress_o)
    else $error("a_r3_a_mismatch");

  a_r4_b_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_i && instr_i[30] && (flags_o[1] != instr_i[28])) |-> suppress_o)
    else $error("a_r4_b_mismatch");
endmodule

// File: tb/test_pred_gate.sv
module test_pred_gate;
  localparam int N_WR = 2;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            instr_valid_i = 1'b0;
  logic [31:0]     instr_i = '0;
  logic            exec_en_o, suppress_o;
  logic [N_WR-1:0] flag_wr_valid_i = '0, flag_wr_sel_i = '0, flag_wr_val_i = '0;
  logic [1:0]      flags_o;

  int vectors = 0, errors = 0;
  logic [1:0] rf = 2'b00;   // reference flags: [0]=A, [1]=B
  string last_wr_tag = "R9";

  always #10 clk = ~clk;

  pred_gate #(.N_WR(N_WR)) i_pred_gate (
    .clk_i(clk), .rst_ni(rst_ni), .instr_valid_i(instr_valid_i), .instr_i(instr_i),
    .exec_en_o(exec_en_o), .suppress_o(suppress_o),
    .flag_wr_valid_i(flag_wr_valid_i), .flag_wr_sel_i(flag_wr_sel_i),
    .flag_wr_val_i(flag_wr_val_i), .flags_o(flags_o)
  );

  task automatic chk(input string req, input int act, input int exp, input string what);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle after a falling edge, compare, then advance the model.
  task automatic step(input logic v, input logic [3:0] pn,
                      input logic [N_WR-1:0] wv, input logic [N_WR-1:0] ws,
                      input logic [N_WR-1:0] wd);
    logic ok_a, ok_b, exp_x;
    string tg;
    @(negedge clk);
    instr_valid_i = v;
    instr_i = {pn, 28'($urandom)};
    flag_wr_valid_i = wv; flag_wr_sel_i = ws; flag_wr_val_i = wd;
    #2;
    ok_a  = !pn[3] || (rf[0] == pn[1]);
    ok_b  = !pn[2] || (rf[1] == pn[0]);
    exp_x = v && ok_a && ok_b;
    if (!v)               tg = "R6";
    else if (pn[3:2]==0)  tg = "R2";
    else if (pn[3:2]==2)  tg = "R3";
    else if (pn[3:2]==1)  tg = "R4";
    else                  tg = "R5";
    chk(tg, int'(exec_en_o), int'(exp_x), "exec_en");
    chk("R6", int'(suppress_o), int'(v && !exp_x), "suppress");
    chk(last_wr_tag, int'(flags_o), int'(rf), "flags");
    // model update for next cycle; later port wins
    if (wv == '0) last_wr_tag = "R9";
    else if (wv[0] && wv[1] && ws[0] == ws[1]) last_wr_tag = "R8";
    else last_wr_tag = "R7";
    for (int k = 0; k < N_WR; k++)
      if (wv[k]) rf[ws[k]] = wd[k];
  endtask

  initial begin
    #5;
    chk("R1", int'(flags_o), 0, "flags in reset");
    #30;
    chk("R1", int'(flags_o), 0, "flags in reset");
    @(negedge clk); rst_ni = 1'b1;
    last_wr_tag = "R1";
    // R2: open predicate with flags 0
    step(1, 4'b0000, 2'b00, 2'b00, 2'b00);
    // R3: A enable, require 1 against A=0 -> suppressed; also set A=1
    step(1, 4'b1010, 2'b01, 2'b00, 2'b01);
    // R7: next instruction sees A=1 at once
    step(1, 4'b1010, 2'b00, 2'b00, 2'b00);
    step(1, 4'b1000, 2'b00, 2'b00, 2'b00);
    // R4: B enable, require 0 with B=0, then set B=1
    step(1, 4'b0100, 2'b01, 2'b01, 2'b01);
    step(1, 4'b0100, 2'b00, 2'b00, 2'b00);
    step(1, 4'b0101, 2'b00, 2'b00, 2'b00);
    // R5: both enables
    step(1, 4'b1111, 2'b00, 2'b00, 2'b00);
    step(1, 4'b1110, 2'b00, 2'b00, 2'b00);
    // R8: collision on A, port 1 stores 0
    step(1, 4'b1111, 2'b11, 2'b00, 2'b01);
    step(1, 4'b1111, 2'b00, 2'b00, 2'b00);
    step(1, 4'b1101, 2'b00, 2'b00, 2'b00);
    // R6: idle word that would pass
    step(0, 4'b0000, 2'b00, 2'b00, 2'b00);
    // random stream
    for (int n = 0; n < 3000; n++)
      step(1'($urandom_range(0, 3) != 0), 4'($urandom), 2'($urandom),
           2'($urandom), 2'($urandom));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule